// File: doc/BRIEF.md
# Timer Input Capture and Interrupt Gating Unit

This block holds a 16-bit timer counter and latches its value into a capture register when the selected event input rises. The event can come from an external capture pin or from an on-chip comparator output. Two 16-bit compare registers raise match flags, and the counter raises a wrap flag. The counter can also run against the capture register as its wrap limit. A mask register and a global enable gate the four flags onto four interrupt request lines.

Software reaches every 16-bit register over an 8-bit bus, one byte at a time. All 16-bit registers share one byte-wide staging register. Reading a low byte parks the matching high byte in the staging register. Writing a high byte only fills the staging register, and the next low-byte write commits both halves at once. This keeps each 16-bit value coherent even while the counter is running.

The bus is a plain single-cycle register port and is always ready, so there is no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational and valid in the same cycle as `bus_rd`. The side effect of a read on the staging register happens at that edge.

Top module: `tcap_top`

## Requirements
- R1: On each rising edge of the selected event input the counter value is copied into the capture register and the capture flag (bit 5) is set. This happens at the third clock edge after the input changes. An input held high causes no further capture.
- R2: Control bit 0 selects the event source: 0 is `cap_pin` and 1 is `acomp_out`. Edges on the source that is not selected have no effect.
- R3: When control bit 1 is 1, the counter wraps to 0 on the tick at which it equals the capture register, and capture events are ignored (the register and flag are unchanged).
- R4: The address map is: counter low/high at 0/1, capture at 2/3, compare A at 4/5, compare B at 6/7, mask at 8, flags at 9, control at 10. A low-byte read returns the low half and loads the staging register with that register's high half. A high-byte read returns the staging register.
- R5: A high-byte write loads only the staging register. A low-byte write commits {staging, data} to the 16-bit register in one cycle. The staging register is shared by all 16-bit registers.
- R6: The mask register keeps only bits 5, 2, 1 and 0. All other bits read as 0.
- R7: `irq_req[3]` (capture), `irq_req[2]` (compare B), `irq_req[1]` (compare A) and `irq_req[0]` (overflow) are each 1 exactly when `gie` is 1, the mask bit is 1 and the flag bit is 1. The mask and flag bits are 5, 2, 1 and 0 in that order.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a flag's event and its clear fall in the same cycle, the flag ends up set.
- R9: The overflow flag (bit 0) is set on the tick at which the counter wraps: from 0xFFFF, or from the capture value in the mode of R3.
- R10: A compare flag (bit 1 for A, bit 2 for B) is set on a tick at which the counter equals that compare register.
- R11: After reset, every register, the staging register and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable (prescaled count strobe) |
| cap_pin | input | 1 | External capture event, asynchronous |
| acomp_out | input | 1 | Comparator capture event, asynchronous |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq_req | output | 4 | Interrupt requests {capture, compare B, compare A, overflow} |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a counter wrap together with a software clear of the overflow flag. The bench forces it by loading 0xFFFF and then, in one cycle, raising `tick` and writing 1 to flag bit 0. The flag must read back as set, while a compare flag cleared by the same write must read back as clear. The second pair is a low-byte read together with the staging register being shared across registers. Table vectors interleave accesses to different 16-bit registers, and high bytes are judged against whatever the most recent low read or high write left in the staging register.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CNT_L  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT_H  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CAP_L  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CAP_H  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMPA_L = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMPA_H = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMPB_L = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMPB_H = 4'd7;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'd8;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd9;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd10;

  // flag / mask bit positions
  localparam int B_OVF  = 0;
  localparam int B_CMPA = 1;
  localparam int B_CMPB = 2;
  localparam int B_CAP  = 5;
  localparam logic [BYTE_W-1:0] IRQ_BITS = 8'h27;

  // number of 16-bit registers behind the byte port (counter + three)
  localparam int NWORD = 4;
endpackage

// File: rtl/tcap_evt_sync.sv
module tcap_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign pulse = sh_q[STAGES-1] & ~prev_q;

  // R1: one event per edge
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/tcap_counter.sv
module tcap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         top_sel,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] limit;

  assign limit = top_sel ? top_val : {W{1'b1}};
  assign wrap  = tick && !load && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (tick)  cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R3 / R9: wrap returns to zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && top_sel && cnt == top_val) |=> (cnt == '0));
  a_r9_plain_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !top_sel && cnt == {W{1'b1}}) |=> (cnt == '0));
endmodule

// File: rtl/tcap_regfile.sv
module tcap_regfile
  import tcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] cnt,
  input  logic              cap_evt,
  output logic [BYTE_W-1:0] temp_q,
  output logic              cnt_load,
  output logic [WORD_W-1:0] cnt_load_val,
  output logic [WORD_W-1:0] cap_q,
  output logic [WORD_W-1:0] cmpa_q,
  output logic [WORD_W-1:0] cmpb_q
);
  localparam int NREG = NWORD - 1;

  logic              word_sp;   // address falls in the 16-bit space
  logic [1:0]        pair;
  logic [WORD_W-1:0] words [NWORD];
  logic [WORD_W-1:0] r_q   [NREG];
  logic [NWORD-1:0]  wr_lo;

  assign word_sp = (bus_addr < ADDR_W'(2 * NWORD));
  assign pair    = bus_addr[2:1];

  assign words[0] = cnt;
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_words
      assign words[i+1] = r_q[i];
    end
  endgenerate

  generate
    for (genvar i = 0; i < NWORD; i++) begin : g_wr
      assign wr_lo[i] = bus_wr && word_sp && !bus_addr[0] && (pair == 2'(i));
    end
  endgenerate

  // shared staging byte
  always_ff @(posedge clk) begin
    if (!rst_n)
      temp_q <= '0;
    else if (bus_wr && word_sp && bus_addr[0])
      temp_q <= bus_wdata;
    else if (bus_rd && word_sp && !bus_addr[0])
      temp_q <= words[pair][WORD_W-1:BYTE_W];
  end

  assign cnt_load     = wr_lo[0];
  assign cnt_load_val = {temp_q, bus_wdata};

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_cap
        always_ff @(posedge clk) begin
          if (!rst_n)          r_q[i] <= '0;
          else if (wr_lo[i+1]) r_q[i] <= {temp_q, bus_wdata};
          else if (cap_evt)    r_q[i] <= cnt;
        end
        // R1: capture copies the counter
        a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
          (cap_evt && !wr_lo[i+1]) |=> (r_q[i] == $past(cnt)));
      end else begin : g_cmp
        always_ff @(posedge clk) begin
          if (!rst_n)          r_q[i] <= '0;
          else if (wr_lo[i+1]) r_q[i] <= {temp_q, bus_wdata};
        end
      end
      // R5: atomic commit of both halves
      a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo[i+1] |=> (r_q[i] == {$past(temp_q), $past(bus_wdata)}));
    end
  endgenerate

  assign cap_q  = r_q[0];
  assign cmpa_q = r_q[1];
  assign cmpb_q = r_q[2];
endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cap_pin,
  input  logic              acomp_out,
  input  logic              gie,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [3:0]        irq_req
);
  logic [1:0]        ctrl_q;     // [0] source select, [1] capture-as-limit
  logic [BYTE_W-1:0] mask_q;
  logic [BYTE_W-1:0] flag_q;
  logic [BYTE_W-1:0] flag_set;
  logic [BYTE_W-1:0] flag_clr;

  logic              evt_src;
  logic              evt_pulse;
  logic              cap_evt;
  logic [WORD_W-1:0] cnt;
  logic              wrap;
  logic              cnt_load;
  logic [WORD_W-1:0] cnt_load_val;
  logic [BYTE_W-1:0] temp_q;
  logic [WORD_W-1:0] cap_q;
  logic [WORD_W-1:0] cmpa_q;
  logic [WORD_W-1:0] cmpb_q;

  assign evt_src = ctrl_q[0] ? acomp_out : cap_pin;

  tcap_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (evt_src),
    .pulse (evt_pulse)
  );

  assign cap_evt = evt_pulse && !ctrl_q[1];

  tcap_regfile u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .cnt          (cnt),
    .cap_evt      (cap_evt),
    .temp_q       (temp_q),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .cap_q        (cap_q),
    .cmpa_q       (cmpa_q),
    .cmpb_q       (cmpb_q)
  );

  tcap_counter #(.W(WORD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .top_sel  (ctrl_q[1]),
    .top_val  (cap_q),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  // control and mask
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[1:0];
      if (bus_addr == A_MASK) mask_q <= bus_wdata & IRQ_BITS;
    end
  end

  // flag set sources
  always_comb begin
    flag_set         = '0;
    flag_set[B_CAP]  = cap_evt;
    flag_set[B_OVF]  = wrap;
    flag_set[B_CMPA] = tick && (cnt == cmpa_q);
    flag_set[B_CMPB] = tick && (cnt == cmpb_q);
  end

  assign flag_clr = (bus_wr && bus_addr == A_FLAG) ? (bus_wdata & IRQ_BITS) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  generate
    for (genvar b = 0; b < BYTE_W; b++) begin : g_flag_chk
      if (IRQ_BITS[b]) begin : g_live
        // R8: set beats clear
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
          flag_set[b] |=> flag_q[b]);
      end
    end
  endgenerate

  assign irq_req = {4{gie}} & {mask_q[B_CAP]  & flag_q[B_CAP],
                               mask_q[B_CMPB] & flag_q[B_CMPB],
                               mask_q[B_CMPA] & flag_q[B_CMPA],
                               mask_q[B_OVF]  & flag_q[B_OVF]};

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CNT_L:  bus_rdata = cnt[BYTE_W-1:0];
        A_CAP_L:  bus_rdata = cap_q[BYTE_W-1:0];
        A_CMPA_L: bus_rdata = cmpa_q[BYTE_W-1:0];
        A_CMPB_L: bus_rdata = cmpb_q[BYTE_W-1:0];
        A_CNT_H, A_CAP_H, A_CMPA_H, A_CMPB_H: bus_rdata = temp_q;
        A_MASK:   bus_rdata = mask_q;
        A_FLAG:   bus_rdata = flag_q;
        A_CTRL:   bus_rdata = {{(BYTE_W-2){1'b0}}, ctrl_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R7: no request without global enable
  a_r7_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == 4'b0000));
  // R3: capture ignored while capture acts as limit
  a_r3_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && !(bus_wr && bus_addr == A_CAP_L)) |=> $stable(cap_q));
endmodule

// File: tb/test_tcap_top.sv
module test_tcap_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cap_pin = 1'b0;
  logic       acomp_out = 1'b0;
  logic       gie = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] irq_req;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tcap_top i_tcap_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cap_pin   (cap_pin),
    .acomp_out (acomp_out),
    .gie       (gie),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req)
  );

  // {kind(1: read-check, 0: write), addr[3:0], data[7:0], expect[7:0]}
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd7, 8'h5A, 8'h00},  // R5 stage high of compare B
    {1'b0, 4'd6, 8'hC3, 8'h00},  // R5 commit compare B
    {1'b0, 4'd5, 8'hAB, 8'h00},
    {1'b0, 4'd4, 8'hCD, 8'h00},
    {1'b1, 4'd4, 8'h00, 8'hCD},  // R4 low read, staging <= AB
    {1'b1, 4'd5, 8'h00, 8'hAB},
    {1'b1, 4'd6, 8'h00, 8'hC3},  // R4 staging <= 5A
    {1'b1, 4'd7, 8'h00, 8'h5A},
    {1'b0, 4'd5, 8'h11, 8'h00},  // R5 staging only
    {1'b1, 4'd7, 8'h00, 8'h11},  // R4 high read returns staging
    {1'b1, 4'd4, 8'h00, 8'hCD},  // staging <= AB
    {1'b0, 4'd4, 8'h77, 8'h00},  // R5 shared staging commits AB77
    {1'b1, 4'd4, 8'h00, 8'h77},
    {1'b1, 4'd5, 8'h00, 8'hAB},
    {1'b0, 4'd8, 8'hFF, 8'h00},  // R6
    {1'b1, 4'd8, 8'h00, 8'h27},
    {1'b0, 4'd8, 8'h00, 8'h00},
    {1'b1, 4'd8, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    // R11 reset state
    @(negedge clk);
    chk("R11 irq", {4'b0, irq_req}, 8'h00);
    for (int a = 0; a <= 10; a++) rd_chk("R11 reg", 4'(a), 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) rd_chk("R4/R5/R6 vector", VEC[i][19:16], VEC[i][7:0]);
      else            wr(VEC[i][19:16], VEC[i][15:8]);
    end

    // R1 capture
    wr(4'd1, 8'h12); wr(4'd0, 8'h34);
    @(negedge clk); cap_pin = 1'b1;
    wait_n(4);
    rd_chk("R1 flag", 4'd9, 8'h20);
    rd_chk("R1 cap lo", 4'd2, 8'h34);
    rd_chk("R1 cap hi", 4'd3, 8'h12);
    wr(4'd9, 8'h20);
    wr(4'd1, 8'h22); wr(4'd0, 8'h22);
    wait_n(5);
    rd_chk("R1 held high", 4'd9, 8'h00);
    rd_chk("R1 held cap", 4'd2, 8'h34);

    // R2 source select
    cap_pin = 1'b0; wait_n(4);
    wr(4'd10, 8'h01);
    cap_pin = 1'b1; wait_n(4);
    rd_chk("R2 pin ignored flag", 4'd9, 8'h00);
    rd_chk("R2 pin ignored cap", 4'd2, 8'h34);
    acomp_out = 1'b1; wait_n(4);
    rd_chk("R2 comparator flag", 4'd9, 8'h20);
    rd_chk("R2 comparator cap", 4'd2, 8'h22);
    wr(4'd9, 8'h20);
    acomp_out = 1'b0; cap_pin = 1'b0; wait_n(4);
    wr(4'd10, 8'h00);

    // R3 / R9 capture value as limit
    wr(4'd3, 8'h00); wr(4'd2, 8'h05);
    wr(4'd1, 8'h00); wr(4'd0, 8'h03);
    wr(4'd10, 8'h02);
    @(negedge clk); tick = 1'b1;
    wait_n(3);
    tick = 1'b0;
    rd_chk("R3 wrapped count", 4'd0, 8'h00);
    rd_chk("R9 overflow at limit", 4'd9, 8'h01);
    cap_pin = 1'b1; wait_n(4);
    rd_chk("R3 capture ignored flag", 4'd9, 8'h01);
    rd_chk("R3 capture ignored cap", 4'd2, 8'h05);
    cap_pin = 1'b0; wait_n(4);
    wr(4'd9, 8'h01);
    wr(4'd10, 8'h00);

    // R10 compare
    wr(4'd5, 8'h00); wr(4'd4, 8'h10);
    wr(4'd7, 8'h00); wr(4'd6, 8'h20);
    wr(4'd1, 8'h00); wr(4'd0, 8'h0E);
    @(negedge clk); tick = 1'b1;
    wait_n(3);
    tick = 1'b0;
    rd_chk("R10 compare A only", 4'd9, 8'h02);
    rd_chk("R10 count", 4'd0, 8'h11);

    // R7 gating
    wr(4'd8, 8'h27);
    @(negedge clk); #1;
    chk("R7 gie low", {4'b0, irq_req}, 8'h00);
    gie = 1'b1; #1;
    chk("R7 compare A request", {4'b0, irq_req}, 8'h02);
    wr(4'd8, 8'h25); #1;
    chk("R7 masked", {4'b0, irq_req}, 8'h00);
    wr(4'd8, 8'h27);

    // R8 set and clear collide
    wr(4'd1, 8'hFF); wr(4'd0, 8'hFF);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    rd_chk("R9 wrap from all ones", 4'd9, 8'h03);
    wr(4'd1, 8'hFF); wr(4'd0, 8'hFF);
    @(negedge clk);
    tick = 1'b1; bus_addr = 4'd9; bus_wdata = 8'h03; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd_chk("R8 set wins", 4'd9, 8'h01);
    #1 chk("R7 overflow request", {4'b0, irq_req}, 8'h01);
    wr(4'd9, 8'h01);
    rd_chk("R8 clear", 4'd9, 8'h00);
    #1 chk("R7 no request", {4'b0, irq_req}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule